// File: doc/BRIEF.md
# I2C Controller Status Register

This block is the status byte of an I2C controller, seen by the host through a plain register port. It gathers events from the bus engine, the master data buffer, power management and the slave logic. Two sticky flags record a fault in the requested master transfer and a STOP that a fault forced onto the bus. Live copies of the transfer-pending and bus-busy lines sit beside them. Software reads the pending and error bits together to judge the outcome: pending low with error low means the transfer finished with all data moved; pending low with error high means it finished short; pending high means it is still running, with or without a fault already seen.

Two bits report master buffer occupancy. They are refreshed on a fixed schedule after each host access to the buffer, and that schedule is longer for a double-byte access than for a byte access. One more bit acknowledges a sleep request from power management. Another summarises the low slave status flags. Software clears the sticky bits by writing ones to them. While the interface is asleep, only the sleep bit responds to writes.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset, bits 1, 2, 3, 4 and 6 of `rd_data` read 0. Bits 0, 5 and 7 follow their live inputs.
- R2: Bit 0 reads 1 exactly when any of bits 3..0 of `slv_stat` is 1. Higher `slv_stat` bits are ignored, and writes have no effect on bit 0.
- R3: Bit 5 mirrors `xfer_pend` and bit 7 mirrors `bus_busy`. Writing 1 to either bit changes nothing.
- R4: An `err_evt` pulse sets bit 6 at the next edge. Bit 6 then stays set until a write with `reg_wdata[6]`=1 clears it at that write's edge.
- R5: An `err_stop_evt` pulse sets both bit 4 and bit 6 at the next edge. Writing 1 to bit 4 clears bit 4 only.
- R6: When a hardware set and a software clear reach the same bit in the same cycle, the bit is 1 afterwards. This applies to bits 1, 4 and 6.
- R7: After a byte buffer access (`buf_acc`=1, `buf_wide`=0) at edge E0, bits 3:2 keep their old value after E0. They show `{buf_full, buf_has_data}` as sampled at E1 once E1 has passed.
- R8: After a double-byte access (`buf_wide`=1) at E0, bits 3:2 keep their old value after E0 and E1. They show the live flags sampled at E2 once E2 has passed.
- R9: With no access window open, bits 3:2 follow `{buf_full, buf_has_data}` one edge late.
- R10: A rising edge of `sleep_init` sets bit 1 at the next edge. A level that simply stays high does not set it again.
- R11: Bit 1 is cleared in three cases: `asleep` and `start_det` both high, `sleep_init` low, or a write with `reg_wdata[1]`=1.
- R12: While `asleep` is 1, a write leaves bits 4 and 6 unchanged. A write to bit 1 still takes effect.
- R13: Writing 8'hFF leaves bit 0 showing the slave summary and clears bits 1, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe for the status byte |
| reg_wdata | input | 8 | Host write data; a 1 clears writable bits |
| rd_data | output | 8 | Status byte as read by the host |
| xfer_pend | input | 1 | Bus engine: master transfer pending |
| bus_busy | input | 1 | Bus engine: bus busy |
| err_evt | input | 1 | Bus engine: transfer fault pulse |
| err_stop_evt | input | 1 | Bus engine: fault that forced a STOP |
| buf_acc | input | 1 | Host accessed the master data buffer |
| buf_wide | input | 1 | That access was double-byte |
| buf_has_data | input | 1 | Live buffer non-empty flag |
| buf_full | input | 1 | Live buffer full flag |
| sleep_init | input | 1 | Power management sleep-init level |
| asleep | input | 1 | Interface is in sleep mode |
| start_det | input | 1 | START seen on the bus |
| slv_stat | input | 8 | Slave status flag vector |

## Verification
Two pairs of functions can act on the same bit in the same cycle. A fault event from the bus engine can meet a clearing host write, and a rising sleep-init can meet a write of 1 to the sleep bit. The bench drives both members of each pair at the same negative edge, reads the bit after the shared edge, and expects 1. It also lines up a buffer access with a change of the live occupancy flags, and checks the old value, then the new one, at the edge counts that the access size dictates.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   // bit positions of the status byte
   localparam int unsigned SB_SLV   = 0;
   localparam int unsigned SB_SLEEP = 1;
   localparam int unsigned SB_HAS   = 2;
   localparam int unsigned SB_FULL  = 3;
   localparam int unsigned SB_STOP  = 4;
   localparam int unsigned SB_PEND  = 5;
   localparam int unsigned SB_ERR   = 6;
   localparam int unsigned SB_BUSY  = 7;
   localparam int unsigned STAT_W   = 8;

   // sticky fault flags held in one bank
   localparam int unsigned NSTICKY  = 2;
   localparam int unsigned SK_STOP  = 0;
   localparam int unsigned SK_ERR   = 1;

   typedef struct packed {
      logic busy;
      logic err;
      logic pend;
      logic stop;
      logic full;
      logic has;
      logic sleep;
      logic slv;
   } stat_t;
endpackage

// File: rtl/i2c_stat_sticky.sv
module i2c_stat_sticky #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("i2c_stat_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        q[i] <= 1'b0;
         else if (set[i])   q[i] <= 1'b1;   // hardware set has priority
         else if (clr[i])   q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_stat_occ.sv
module i2c_stat_occ #(
   parameter int unsigned BYTE_LAT = 2,
   parameter int unsigned WIDE_LAT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc,
   input  logic       wide,
   input  logic [1:0] live,
   output logic [1:0] occ
);
   localparam int unsigned MAXL = (WIDE_LAT > BYTE_LAT) ? WIDE_LAT : BYTE_LAT;
   localparam int unsigned CW   = $clog2(MAXL + 1);
   localparam logic [CW-1:0] BY_LD = CW'(BYTE_LAT - 1);
   localparam logic [CW-1:0] WD_LD = CW'(WIDE_LAT - 1);
   localparam logic [CW-1:0] ONE   = CW'(1);

   if (BYTE_LAT < 1 || WIDE_LAT < 1) begin : g_bad_lat
      $error("i2c_stat_occ: latencies must be at least 1");
   end

   logic [CW-1:0] dly;
   logic [CW-1:0] ld_v;

   assign ld_v = wide ? WD_LD : BY_LD;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly <= '0;
         occ <= 2'b00;
      end else if (acc) begin
         if (ld_v == '0) begin
            dly <= '0;
            occ <= live;
         end else begin
            dly <= ld_v;
         end
      end else if (dly != '0) begin
         dly <= dly - ONE;
         if (dly == ONE) occ <= live;
      end else begin
         occ <= live;
      end
   end
endmodule

// File: rtl/i2c_stat_sleep.sv
module i2c_stat_sleep (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic asleep,
   input  logic start_det,
   input  logic sw_clr,
   output logic req
);
   logic init_q;
   logic rise;

   assign rise = init & ~init_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         init_q <= init;
         if (rise)                                 req <= 1'b1;
         else if ((asleep & start_det) | ~init | sw_clr) req <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg #(
   parameter int unsigned SLV_W    = 8,
   parameter int unsigned SLV_SUM  = 4,
   parameter int unsigned BYTE_LAT = 2,
   parameter int unsigned WIDE_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       rd_data,
   input  logic             xfer_pend,
   input  logic             bus_busy,
   input  logic             err_evt,
   input  logic             err_stop_evt,
   input  logic             buf_acc,
   input  logic             buf_wide,
   input  logic             buf_has_data,
   input  logic             buf_full,
   input  logic             sleep_init,
   input  logic             asleep,
   input  logic             start_det,
   input  logic [SLV_W-1:0] slv_stat
);
   import i2c_stat_pkg::*;

   if (SLV_SUM < 1 || SLV_SUM > SLV_W) begin : g_bad_sum
      $error("i2c_stat_reg: SLV_SUM must lie in 1..SLV_W");
   end

   logic [NSTICKY-1:0] sk_set, sk_clr, sk_q;
   logic [1:0]         occ;
   logic               sleep_q;
   logic               wr_awake;
   logic               slv_any;
   stat_t              st;

   assign wr_awake = reg_wr & ~asleep;

   assign sk_set[SK_STOP] = err_stop_evt;
   assign sk_set[SK_ERR]  = err_evt | err_stop_evt;
   assign sk_clr[SK_STOP] = wr_awake & reg_wdata[SB_STOP];
   assign sk_clr[SK_ERR]  = wr_awake & reg_wdata[SB_ERR];

   i2c_stat_sticky #(.N(NSTICKY)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sk_set),
      .clr   (sk_clr),
      .q     (sk_q)
   );

   i2c_stat_occ #(.BYTE_LAT(BYTE_LAT), .WIDE_LAT(WIDE_LAT)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (buf_acc),
      .wide  (buf_wide),
      .live  ({buf_full, buf_has_data}),
      .occ   (occ)
   );

   i2c_stat_sleep u_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (sleep_init),
      .asleep    (asleep),
      .start_det (start_det),
      .sw_clr    (reg_wr & reg_wdata[SB_SLEEP]),
      .req       (sleep_q)
   );

   if (SLV_SUM == 1) begin : g_sum_one
      assign slv_any = slv_stat[0];
   end else begin : g_sum_many
      assign slv_any = |slv_stat[SLV_SUM-1:0];
   end

   always_comb begin
      st       = '0;
      st.slv   = slv_any;
      st.sleep = sleep_q;
      st.has   = occ[0];
      st.full  = occ[1];
      st.stop  = sk_q[SK_STOP];
      st.pend  = xfer_pend;
      st.err   = sk_q[SK_ERR];
      st.busy  = bus_busy;
   end

   assign rd_data = st;
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk #(
   parameter int unsigned BYTE_LAT = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic       err_evt,
   input logic       err_stop_evt,
   input logic       buf_acc,
   input logic       sleep_init,
   input logic       asleep,
   input logic [7:0] rd_data
);
   // R4: fault event sets error flag
   a_r4_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> rd_data[6]);

   // R5: forced STOP sets both flags
   a_r5_stop_both: assert property (@(posedge clk) disable iff (!rst_n)
      err_stop_evt |=> (rd_data[4] && rd_data[6]));

   // R7: occupancy holds right after an access
   a_r7_occ_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_acc && BYTE_LAT > 1) |=> $stable(rd_data[3:2]));

   // R10: rising sleep-init sets sleep bit
   a_r10_sleep_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_init && !$past(sleep_init)) |=> rd_data[1]);

   // R12: writes while asleep do not touch error flag
   a_r12_asleep_err: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && reg_wr && !err_evt && !err_stop_evt) |=> (rd_data[6] == $past(rd_data[6])));

   // R12: nor the forced STOP flag
   a_r12_asleep_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && reg_wr && !err_stop_evt) |=> (rd_data[4] == $past(rd_data[4])));
endmodule

bind i2c_stat_reg i2c_stat_chk #(.BYTE_LAT(BYTE_LAT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .err_evt      (err_evt),
   .err_stop_evt (err_stop_evt),
   .buf_acc      (buf_acc),
   .sleep_init   (sleep_init),
   .asleep       (asleep),
   .rd_data      (rd_data)
);

// File: tb/sim_i2c_stat_reg.sv
`timescale 1ns/1ps
module sim_i2c_stat_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] rd_data;
   logic       xfer_pend = 1'b0, bus_busy = 1'b0;
   logic       err_evt = 1'b0, err_stop_evt = 1'b0;
   logic       buf_acc = 1'b0, buf_wide = 1'b0;
   logic       buf_has_data = 1'b0, buf_full = 1'b0;
   logic       sleep_init = 1'b0, asleep = 1'b0, start_det = 1'b0;
   logic [7:0] slv_stat = 8'h00;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_stat_reg u0 (.*);

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] mask, input logic [7:0] exp);
      nvec++;
      if ((rd_data & mask) !== (exp & mask)) begin
         nbad++;
         $display("FAIL %s: got %h expected %h (mask %h)", tag, rd_data & mask, exp & mask, mask);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      slv_stat = 8'h04; xfer_pend = 1'b1; bus_busy = 1'b0;
      tick(); tick();
      // R1: reset state, mirrors live
      chk("R1", 8'hFF, 8'h21);
      rst_n = 1'b1;
      slv_stat = 8'h00; xfer_pend = 1'b0;
      tick();
      chk("R1", 8'hFF, 8'h00);

      // R2: sweep every slave vector
      for (int v = 0; v < 256; v++) begin
         slv_stat = v[7:0];
         #1;
         chk("R2", 8'h01, {7'b0, |v[3:0]});
         if (v == 255) begin
            wr(8'h01);
            chk("R2", 8'h01, 8'h01);
         end
      end
      slv_stat = 8'h00;

      // R3: pending / busy mirrors, write has no effect
      for (int v = 0; v < 4; v++) begin
         xfer_pend = v[0]; bus_busy = v[1];
         #1;
         chk("R3", 8'hA0, {v[1], 1'b0, v[0], 5'b0});
         wr(8'hA0);
         chk("R3", 8'hA0, {v[1], 1'b0, v[0], 5'b0});
      end
      xfer_pend = 1'b0; bus_busy = 1'b0;

      // R4: error set, sticky, cleared by write
      err_evt = 1'b1; tick(); err_evt = 1'b0;
      chk("R4", 8'h50, 8'h40);
      tick(); tick();
      chk("R4", 8'h50, 8'h40);
      wr(8'h10);
      chk("R4", 8'h50, 8'h40);
      wr(8'h40);
      chk("R4", 8'h50, 8'h00);

      // R5: forced STOP sets both; bit 4 clears alone
      err_stop_evt = 1'b1; tick(); err_stop_evt = 1'b0;
      chk("R5", 8'h50, 8'h50);
      wr(8'h10);
      chk("R5", 8'h50, 8'h40);
      wr(8'h40);
      chk("R5", 8'h50, 8'h00);

      // R6: set wins over same-cycle clear
      err_evt = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h40;
      tick();
      err_evt = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
      chk("R6", 8'h40, 8'h40);
      err_stop_evt = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h50;
      tick();
      err_stop_evt = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
      chk("R6", 8'h50, 8'h50);
      wr(8'h50);
      chk("R6", 8'h50, 8'h00);

      // R7 / R8: every old/new flag pair for both access sizes
      for (int w = 0; w < 2; w++) begin
         for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
               buf_full = o[1]; buf_has_data = o[0];
               tick(); tick();
               // R9: idle tracking one edge late
               chk("R9", 8'h0C, {4'b0, o[1:0], 2'b0});
               buf_acc = 1'b1; buf_wide = w[0];
               buf_full = n[1]; buf_has_data = n[0];
               tick();
               buf_acc = 1'b0; buf_wide = 1'b0;
               chk(w ? "R8" : "R7", 8'h0C, {4'b0, o[1:0], 2'b0});
               tick();
               if (w == 0) begin
                  chk("R7", 8'h0C, {4'b0, n[1:0], 2'b0});
               end else begin
                  chk("R8", 8'h0C, {4'b0, o[1:0], 2'b0});
                  tick();
                  chk("R8", 8'h0C, {4'b0, n[1:0], 2'b0});
               end
            end
         end
      end
      // R9: idle change appears after one edge, not before
      buf_full = 1'b0; buf_has_data = 1'b0;
      tick();
      buf_has_data = 1'b1;
      #1;
      chk("R9", 8'h0C, 8'h00);
      tick();
      chk("R9", 8'h0C, 8'h04);
      buf_has_data = 1'b0;
      tick();

      // R10: rising edge sets, steady level does not re-set
      sleep_init = 1'b1; tick();
      chk("R10", 8'h02, 8'h02);
      wr(8'h02);
      chk("R11", 8'h02, 8'h00);
      tick(); tick();
      chk("R10", 8'h02, 8'h00);
      // R11: low sleep_init clears
      sleep_init = 1'b0; tick();
      sleep_init = 1'b1; tick();
      chk("R10", 8'h02, 8'h02);
      sleep_init = 1'b0; tick();
      chk("R11", 8'h02, 8'h00);
      // R11: asleep with START clears; START alone does not
      sleep_init = 1'b1; tick();
      start_det = 1'b1; tick(); start_det = 1'b0;
      chk("R11", 8'h02, 8'h02);
      asleep = 1'b1; start_det = 1'b1; tick(); start_det = 1'b0;
      chk("R11", 8'h02, 8'h00);
      asleep = 1'b0;
      sleep_init = 1'b0; tick();
      // R6: rising sleep-init beats same-cycle write of 1
      sleep_init = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h02;
      tick();
      reg_wr = 1'b0; reg_wdata = 8'h00;
      chk("R6", 8'h02, 8'h02);

      // R12: asleep writes only reach bit 1
      err_stop_evt = 1'b1; tick(); err_stop_evt = 1'b0;
      asleep = 1'b1;
      wr(8'h50);
      chk("R12", 8'h52, 8'h52);
      wr(8'hFF);
      chk("R12", 8'h52, 8'h50);
      asleep = 1'b0;
      sleep_init = 1'b0;

      // R13: full clear keeps slave summary
      slv_stat = 8'h08; sleep_init = 1'b1; tick();
      wr(8'hFF);
      chk("R13", 8'hFF, 8'h01);
      slv_stat = 8'h00; sleep_init = 1'b0;
      tick();
      chk("R13", 8'hFF, 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule